// File: doc/BRIEF.md
# DMA Channel Request Generator

This block decides, for one DMA channel, when a transfer request is raised toward the downstream transfer engine. A 4-bit source-select field chooses where the request comes from. In auto mode the channel raises a request by itself as soon as it is allowed to run, which suits memory-to-memory copies and peripherals that cannot ask for data. In external mode the request comes from an active-low pin, sampled either by level or by falling edge. In peripheral mode it comes from an on-chip request line. For external mode the block also reports whether the channel works with two addresses or with one address and an acknowledged device.

Every request is qualified by the channel enable, the global enable, the transfer-end flag, the address-error flag and the abort flag. A transfer-end mask lets level-detected external transfers continue after transfer end. Edge-detected transfers never ignore transfer end. A small state machine holds the request. It has three states: `ST_IDLE` (no request), `ST_REQ` (request driven) and `ST_ACK` (one-cycle acknowledge). The transitions are:
- `ST_IDLE` to `ST_REQ` when the source asks and the qualifiers allow it.
- `ST_REQ` to `ST_IDLE` when the source drops or a qualifier forbids it.
- `ST_REQ` to `ST_ACK` when grant arrives.
- `ST_ACK` to `ST_IDLE` always.

Top module: `dma_req_gen`

## Requirements
- R1: After reset `req` and `ack` are 0.
- R2: With `src_sel` = 4'b0000 (auto) and all qualifiers passing (`chan_en`=1, `glob_en`=1, `xfer_end`=0, `addr_err`=0, `abort`=0), `req` rises one clock after the qualifiers hold.
- R3: `chan_en`=0, or `xfer_end`=1 in any mode other than level-detected external with `te_mask`=1, keeps `req` at 0.
- R4: `glob_en`=0, `addr_err`=1 or `abort`=1 forces `req` to 0 on the next clock, even with a pending edge request.
- R5: In external mode (`src_sel` 4'b0010 or 4'b0011) with `edge_det`=0, a low on `ext_req_n` passes through two synchronizer flops. `req` rises on the third clock after the pin falls and falls on the third clock after it rises.
- R6: In level-detected external mode, `xfer_end`=1 still allows a request when `te_mask`=1 and blocks it when `te_mask`=0.
- R7: In external mode with `edge_det`=1, a falling edge of the synchronized pin latches a pending request. `req` rises on the fourth clock after the pin falls and stays high after the pin returns high, until grant.
- R8: In edge-detected external mode, `xfer_end`=1 blocks the request even with `te_mask`=1.
- R9: When `grant` is 1 while `req` is 1, `ack` is 1 for exactly one clock on the next cycle and `req` is 0 in that cycle. A granted edge request is cleared.
- R10: `single_addr` is 1 only when `src_sel` = 4'b0011. It is 0 for 4'b0010 and for every other value.
- R11: With `src_sel` = 4'b1000, `req` follows `periph_req` with one clock of delay while the qualifiers pass.
- R12: Any `src_sel` value other than 4'b0000, 4'b0010, 4'b0011 or 4'b1000 gives no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 4 | Request source select |
| edge_det | input | 1 | External pin detection: 1 edge, 0 level |
| te_mask | input | 1 | Transfer-end mask for level-detected external mode |
| chan_en | input | 1 | Channel enable |
| glob_en | input | 1 | Global DMA enable |
| xfer_end | input | 1 | Transfer-end flag |
| addr_err | input | 1 | Address-error flag |
| abort | input | 1 | Non-maskable abort flag |
| ext_req_n | input | 1 | External request pin, active low, asynchronous |
| periph_req | input | 1 | On-chip peripheral request, synchronous |
| grant | input | 1 | Grant from the transfer engine |
| req | output | 1 | Transfer request |
| ack | output | 1 | One-cycle acknowledge after grant |
| single_addr | output | 1 | External channel uses single-address mode |

## Verification
A state machine stuck in the wrong state shows at once: `req` and `ack` come straight from the state register, so it is visible within one clock of the fault. A lost or stale pending edge request shows as a missing `req` on the fourth clock after a falling edge, or as `req` rising again after an acknowledged edge transfer. A wrong qualifier term shows within one clock as `req` raised under a blocking flag, or as `req` held after an abort. A wrong synchronizer depth shifts the level-mode rise away from the third clock.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;
    localparam int unsigned SEL_W = 4;

    localparam logic [SEL_W-1:0] SEL_AUTO       = 4'b0000;
    localparam logic [SEL_W-1:0] SEL_EXT_DUAL   = 4'b0010;
    localparam logic [SEL_W-1:0] SEL_EXT_SINGLE = 4'b0011;
    localparam logic [SEL_W-1:0] SEL_PERIPH     = 4'b1000;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_ACK  = 2'd2
    } req_state_e;
endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= RESET_VAL;
                    else        chain[0] <= d_async;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= RESET_VAL;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/dma_req_edge.sv
module dma_req_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n_sync,
    input  logic arm,
    input  logic clr,
    output logic pending
);
    logic prev_n;
    logic fall;

    assign fall = prev_n & ~pin_n_sync;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_n  <= 1'b1;
            pending <= 1'b0;
        end else begin
            prev_n <= pin_n_sync;
            if (!arm)       pending <= 1'b0;
            else if (fall)  pending <= 1'b1;
            else if (clr)   pending <= 1'b0;
        end
    end
endmodule

// File: rtl/dma_req_gate.sv
module dma_req_gate
    import dma_req_pkg::*;
(
    input  logic [SEL_W-1:0] src_sel,
    input  logic             edge_det,
    input  logic             te_mask,
    input  logic             chan_en,
    input  logic             glob_en,
    input  logic             xfer_end,
    input  logic             addr_err,
    input  logic             abort,
    input  logic             pin_n_sync,
    input  logic             pending,
    input  logic             periph_req,
    output logic             src_req,
    output logic             allow,
    output logic             edge_arm,
    output logic             single_addr
);
    logic is_ext;
    logic level_ext;
    logic te_ok;

    always_comb begin
        is_ext      = (src_sel == SEL_EXT_DUAL) || (src_sel == SEL_EXT_SINGLE);
        level_ext   = is_ext && !edge_det;
        edge_arm    = is_ext && edge_det;
        single_addr = (src_sel == SEL_EXT_SINGLE);

        unique case (src_sel)
            SEL_AUTO:                    src_req = 1'b1;
            SEL_EXT_DUAL, SEL_EXT_SINGLE: src_req = edge_det ? pending : ~pin_n_sync;
            SEL_PERIPH:                  src_req = periph_req;
            default:                     src_req = 1'b0;
        endcase

        te_ok = level_ext ? (!xfer_end || te_mask) : !xfer_end;
        allow = chan_en && glob_en && !addr_err && !abort && te_ok;
    end
endmodule

// File: rtl/dma_req_gen.sv
module dma_req_gen
    import dma_req_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] src_sel,
    input  logic             edge_det,
    input  logic             te_mask,
    input  logic             chan_en,
    input  logic             glob_en,
    input  logic             xfer_end,
    input  logic             addr_err,
    input  logic             abort,
    input  logic             ext_req_n,
    input  logic             periph_req,
    input  logic             grant,
    output logic             req,
    output logic             ack,
    output logic             single_addr
);
    req_state_e state, state_nx;
    logic pin_n_sync;
    logic pending;
    logic src_req, allow, edge_arm;
    logic taken;

    assign taken = (state == ST_REQ) && grant;

    dma_req_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (ext_req_n),
        .q_sync  (pin_n_sync)
    );

    dma_req_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_n_sync (pin_n_sync),
        .arm        (edge_arm),
        .clr        (taken),
        .pending    (pending)
    );

    dma_req_gate u_gate (
        .src_sel     (src_sel),
        .edge_det    (edge_det),
        .te_mask     (te_mask),
        .chan_en     (chan_en),
        .glob_en     (glob_en),
        .xfer_end    (xfer_end),
        .addr_err    (addr_err),
        .abort       (abort),
        .pin_n_sync  (pin_n_sync),
        .pending     (pending),
        .periph_req  (periph_req),
        .src_req     (src_req),
        .allow       (allow),
        .edge_arm    (edge_arm),
        .single_addr (single_addr)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (allow && src_req) state_nx = ST_REQ;
            ST_REQ: begin
                if (!allow || !src_req) state_nx = ST_IDLE;
                else if (grant)         state_nx = ST_ACK;
            end
            ST_ACK:  state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        req = 1'b0;
        ack = 1'b0;
        unique case (state)
            ST_REQ:  req = 1'b1;
            ST_ACK:  ack = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/dma_req_gen_chk.sv
module dma_req_gen_chk
    import dma_req_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [SEL_W-1:0] src_sel,
    input logic             chan_en,
    input logic             glob_en,
    input logic             addr_err,
    input logic             abort,
    input logic             grant,
    input logic             req,
    input logic             ack
);
    logic sel_valid;
    assign sel_valid = (src_sel == SEL_AUTO) || (src_sel == SEL_EXT_DUAL) ||
                       (src_sel == SEL_EXT_SINGLE) || (src_sel == SEL_PERIPH);

    assert_grant_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req && grant) |=> (ack && !req));

    assert_ack_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    assert_abort_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!glob_en || addr_err || abort) |=> !req);

    assert_chan_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> !req);

    assert_bad_sel_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_valid |=> !req);

    assert_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req, ack}));
endmodule

bind dma_req_gen dma_req_gen_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_sel  (src_sel),
    .chan_en  (chan_en),
    .glob_en  (glob_en),
    .addr_err (addr_err),
    .abort    (abort),
    .grant    (grant),
    .req      (req),
    .ack      (ack)
);

// File: tb/tb_dma_req_gen.sv
module tb_dma_req_gen;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] src_sel;
    logic       edge_det, te_mask, chan_en, glob_en, xfer_end, addr_err, abort;
    logic       ext_req_n, periph_req, grant;
    logic       req, ack, single_addr;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #2.5 clk = ~clk;

    dma_req_gen dut (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .edge_det(edge_det),
        .te_mask(te_mask), .chan_en(chan_en), .glob_en(glob_en),
        .xfer_end(xfer_end), .addr_err(addr_err), .abort(abort),
        .ext_req_n(ext_req_n), .periph_req(periph_req), .grant(grant),
        .req(req), .ack(ack), .single_addr(single_addr)
    );

    task automatic chk(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        src_sel = 4'b1111; edge_det = 0; te_mask = 0; chan_en = 1; glob_en = 1;
        xfer_end = 0; addr_err = 0; abort = 0; ext_req_n = 1; periph_req = 0; grant = 0;
        wait_cyc(2);
        rst_n = 1'b1;
        wait_cyc(1);
    endtask

    task automatic t_reset_R1();
        do_reset();
        chk("R1 req", req, 1'b0);
        chk("R1 ack", ack, 1'b0);
    endtask

    task automatic t_auto_R2_R3_R4();
        do_reset();
        chan_en = 0; src_sel = 4'b0000;
        wait_cyc(2);
        chk("R3 chan_en off", req, 1'b0);
        chan_en = 1; xfer_end = 1;
        wait_cyc(2);
        chk("R3 xfer_end auto", req, 1'b0);
        xfer_end = 0;
        wait_cyc(1);
        chk("R2 auto rise", req, 1'b1);
        abort = 1;
        wait_cyc(1);
        chk("R4 abort drop", req, 1'b0);
        abort = 0;
        wait_cyc(1);
        chk("R2 auto re-rise", req, 1'b1);
        addr_err = 1;
        wait_cyc(1);
        chk("R4 addr_err drop", req, 1'b0);
        addr_err = 0; glob_en = 0;
        wait_cyc(2);
        chk("R4 glob_en off", req, 1'b0);
    endtask

    task automatic t_grant_R9();
        do_reset();
        src_sel = 4'b0000;
        wait_cyc(1);
        chk("R9 pre req", req, 1'b1);
        grant = 1;
        wait_cyc(1);
        grant = 0;
        chk("R9 ack high", ack, 1'b1);
        chk("R9 req low in ack", req, 1'b0);
        wait_cyc(1);
        chk("R9 ack one cycle", ack, 1'b0);
    endtask

    task automatic t_level_R5_R10();
        do_reset();
        src_sel = 4'b0010; edge_det = 0;
        #1;
        chk("R10 dual", single_addr, 1'b0);
        ext_req_n = 0;
        wait_cyc(2);
        chk("R5 not yet", req, 1'b0);
        wait_cyc(1);
        chk("R5 rise third clock", req, 1'b1);
        ext_req_n = 1;
        wait_cyc(2);
        chk("R5 still high", req, 1'b1);
        wait_cyc(1);
        chk("R5 fall third clock", req, 1'b0);
        src_sel = 4'b0011;
        #1;
        chk("R10 single", single_addr, 1'b1);
        src_sel = 4'b1000;
        #1;
        chk("R10 periph", single_addr, 1'b0);
    endtask

    task automatic t_mask_R6();
        do_reset();
        src_sel = 4'b0011; edge_det = 0; xfer_end = 1; te_mask = 0; ext_req_n = 0;
        wait_cyc(4);
        chk("R6 unmasked blocks", req, 1'b0);
        te_mask = 1;
        wait_cyc(1);
        chk("R6 masked allows", req, 1'b1);
    endtask

    task automatic t_edge_R7_R9();
        do_reset();
        src_sel = 4'b0010; edge_det = 1;
        ext_req_n = 0;
        wait_cyc(3);
        chk("R7 not yet", req, 1'b0);
        ext_req_n = 1;
        wait_cyc(1);
        chk("R7 rise fourth clock", req, 1'b1);
        wait_cyc(4);
        chk("R7 held after pin high", req, 1'b1);
        grant = 1;
        wait_cyc(1);
        grant = 0;
        chk("R9 edge ack", ack, 1'b1);
        wait_cyc(3);
        chk("R9 pending cleared", req, 1'b0);
    endtask

    task automatic t_edge_mask_R8();
        do_reset();
        src_sel = 4'b0010; edge_det = 1; xfer_end = 1; te_mask = 1;
        ext_req_n = 0;
        wait_cyc(6);
        chk("R8 edge ignores mask", req, 1'b0);
    endtask

    task automatic t_pending_abort_R4();
        do_reset();
        src_sel = 4'b0011; edge_det = 1;
        ext_req_n = 0;
        wait_cyc(4);
        chk("R7 pending req", req, 1'b1);
        glob_en = 0;
        wait_cyc(1);
        chk("R4 pending killed", req, 1'b0);
    endtask

    task automatic t_periph_R11();
        do_reset();
        src_sel = 4'b1000;
        wait_cyc(2);
        chk("R11 idle", req, 1'b0);
        periph_req = 1;
        wait_cyc(1);
        chk("R11 follow high", req, 1'b1);
        periph_req = 0;
        wait_cyc(1);
        chk("R11 follow low", req, 1'b0);
    endtask

    task automatic t_bad_sel_R12();
        do_reset();
        periph_req = 1; ext_req_n = 0;
        src_sel = 4'b0001;
        wait_cyc(4);
        chk("R12 sel 0001", req, 1'b0);
        src_sel = 4'b0100;
        wait_cyc(4);
        chk("R12 sel 0100", req, 1'b0);
        src_sel = 4'b1001;
        wait_cyc(2);
        chk("R12 sel 1001", req, 1'b0);
    endtask

    initial begin
        t_reset_R1();
        t_auto_R2_R3_R4();
        t_grant_R9();
        t_level_R5_R10();
        t_mask_R6();
        t_edge_R7_R9();
        t_edge_mask_R8();
        t_pending_abort_R4();
        t_periph_R11();
        t_bad_sel_R12();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule